// File: doc/BRIEF.md
# Vertical Bus Lane Repair Remapper

This block sits between a memory controller and the vertical die-to-die bus of a stacked memory. It carries a request's address and write data on the bus lanes. When a lane has been marked broken, it moves that lane's traffic onto a standby lane. Standby lanes are not extra wires. They are ordinary data lanes picked at design time: slot `s` owns the data lane of bit `DATA_W-1-s`. The bit that a standby lane would normally carry is pushed out for that cycle, so it is written through a side port into ECC storage on every write. On the matching read, the block takes that bit back from ECC storage and puts it back in its place.

Address lanes and data lanes can both be repaired. This matters most for address lanes: one dead address lane with no repair cuts off half of the array, while a dead data lane costs only a few bit-lines. Repairs are set up through a small configuration port. Each configuration write names one lane and one standby slot. A slot serves at most one broken lane. A repair stays in place until reset.

When no repair is active, the bus image is the host request unchanged and the ECC side port does nothing. Request and return paths each take one registered cycle, with or without repairs.

Top module: `tsv_lane_remap`

## Requirements
- R1: While `rst` is high, and in the cycle after it, every output is zero and no lane is repaired.
- R2: With no repair active, `phy_tx` carries the request unchanged. Lane `i < ADDR_W` carries `host_addr[i]`. Lane `ADDR_W+j` carries `host_wdata[j]` on writes and 0 on reads. `ecc_we`, `ecc_re`, `ecc_addr`, `ecc_mask` and `ecc_wdata` all stay 0.
- R3: A configuration write with `cfg_lane < ADDR_W+DATA_W-N_SB`, to a free slot `cfg_slot`, on a lane not yet repaired, is accepted without `cfg_err`. It takes effect from the next request on. Slot `s` uses bus lane `ADDR_W+DATA_W-1-s`.
- R4: For each slot `s` in use with broken lane `k`, the standby lane `ADDR_W+DATA_W-1-s` of `phy_tx` carries logical bit `k` and lane `k` is driven 0. All other lanes are unchanged. Address-lane and data-lane repairs work the same way.
- R5: On a write while any slot is in use, `ecc_we` rises together with `phy_valid`. `ecc_addr` equals the request address and `ecc_mask` shows the slots in use. `ecc_wdata[s]` equals `host_wdata[DATA_W-1-s]` for a used slot and is 0 for an unused slot.
- R6: On a read while any slot is in use, `ecc_re` rises together with `phy_valid`, `ecc_we` stays 0, and `ecc_addr` and `ecc_mask` are as in R5.
- R7: `host_rdata` is built from `phy_rx`, with two substitutions. For each used slot `s`, bit `DATA_W-1-s` comes from `ecc_rdata[s]`. When the broken lane of slot `s` is data lane `j`, bit `j` comes from `phy_rx[DATA_W-1-s]`, and the value on the broken lane is ignored.
- R8: A configuration write to a slot that another lane already owns raises `cfg_err` for one cycle, one cycle later. It leaves all mappings unchanged, and a following request shows no second swap.
- R9: A configuration write naming a standby lane or a lane index at or above `ADDR_W+DATA_W` raises `cfg_err` and changes nothing.
- R10: A repair is sticky. A new configuration write for an already repaired lane is ignored without `cfg_err`, and only reset clears repairs.
- R11: `phy_valid` and the ECC strobes follow `host_valid` by exactly one cycle. `host_rvalid` and `host_rdata` follow `phy_rvalid` by exactly one cycle, whatever the repair map.
- R12: Data written and then read back through the bus and the ECC port returns unchanged, even when the bits on broken data lanes are corrupted in storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lane | input | 6 | Bus lane to mark broken (address lanes first, then data lanes) |
| cfg_slot | input | 2 | Standby slot to use for the lane |
| cfg_err | output | 1 | Pulse: configuration write rejected |
| host_valid | input | 1 | Host request valid |
| host_we | input | 1 | Host request is a write |
| host_addr | input | 16 | Host address |
| host_wdata | input | 32 | Host write data |
| host_rvalid | output | 1 | Read data valid toward host |
| host_rdata | output | 32 | Restored read data |
| phy_valid | output | 1 | Bus request valid |
| phy_we | output | 1 | Bus request is a write |
| phy_tx | output | 48 | Remapped bus lane image |
| phy_rvalid | input | 1 | Bus read return valid |
| phy_rx | input | 32 | Read return on the data lanes |
| ecc_we | output | 1 | ECC-space write of displaced bits |
| ecc_re | output | 1 | ECC-space read of displaced bits |
| ecc_addr | output | 16 | ECC-space address |
| ecc_mask | output | 4 | Slots in use |
| ecc_wdata | output | 4 | Displaced standby bits, one per slot |
| ecc_rdata | input | 4 | Displaced standby bits returned, aligned with `phy_rvalid` |

## Verification
A corrupted owner entry or slot-use bit in the repair table shows up on `phy_tx` on the very next request, one cycle after `host_valid`. It appears as a lane driven low that should carry data, or a standby lane carrying the wrong bit. It also shows on `ecc_mask` and `ecc_wdata` in that same cycle. A fault in the return merge only shows on `host_rdata` one cycle after a read return. For that reason the bench runs full write-then-read round trips with the broken lanes' stored bits flipped. Configuration faults show on `cfg_err` one cycle after the write. Faults that silently accept or overwrite a mapping show on the next request.

// File: rtl/lane_remap_pkg.sv
package lane_remap_pkg;

  typedef enum logic [1:0] {
    CFG_ACCEPT = 2'd0,
    CFG_KEEP   = 2'd1,
    CFG_REJECT = 2'd2
  } cfg_verdict_e;

  // data-bit position of the standby lane serving a slot
  function automatic int unsigned standby_pos(input int unsigned data_w,
                                              input int unsigned slot);
    return data_w - 1 - slot;
  endfunction

endpackage

// File: rtl/lane_fault_table.sv
module lane_fault_table
  import lane_remap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int N_SB   = 4,
  localparam int LANES = ADDR_W + DATA_W,
  localparam int LW    = $clog2(LANES),
  localparam int SW    = (N_SB > 1) ? $clog2(N_SB) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [LW-1:0]        cfg_lane,
  input  logic [SW-1:0]        cfg_slot,
  output logic [N_SB-1:0]      slot_used,
  output logic [N_SB*LW-1:0]   slot_owner,
  output logic [LANES-1:0]     lane_bad,
  output logic                 cfg_err
);

  localparam int FIRST_SB = LANES - N_SB;

  logic         in_range;
  logic         slot_ok;
  logic         already;
  logic         busy;
  cfg_verdict_e verdict;

  always_comb begin
    in_range = (int'(cfg_lane) < FIRST_SB);
    slot_ok  = (int'(cfg_slot) < N_SB);
    already  = in_range ? lane_bad[cfg_lane] : 1'b0;
    busy     = slot_ok ? slot_used[cfg_slot] : 1'b1;
    if (!in_range || !slot_ok) verdict = CFG_REJECT;
    else if (already)          verdict = CFG_KEEP;
    else if (busy)             verdict = CFG_REJECT;
    else                       verdict = CFG_ACCEPT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_used  <= '0;
      slot_owner <= '0;
      lane_bad   <= '0;
      cfg_err    <= 1'b0;
    end else begin
      cfg_err <= cfg_we && (verdict == CFG_REJECT);
      if (cfg_we && verdict == CFG_ACCEPT) begin
        slot_used[cfg_slot]                <= 1'b1;
        slot_owner[cfg_slot*LW +: LW]      <= cfg_lane;
        lane_bad[cfg_lane]                 <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lane_tx_steer.sv
module lane_tx_steer
  import lane_remap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int N_SB   = 4,
  localparam int LANES = ADDR_W + DATA_W,
  localparam int LW    = $clog2(LANES)
) (
  input  logic [LANES-1:0]     logical,
  input  logic [N_SB-1:0]      slot_used,
  input  logic [N_SB*LW-1:0]   slot_owner,
  input  logic [LANES-1:0]     lane_bad,
  output logic [LANES-1:0]     physical,
  output logic [N_SB-1:0]      displaced
);

  logic [LW-1:0] owner_idx [N_SB];

  for (genvar g = 0; g < N_SB; g++) begin : g_owner
    assign owner_idx[g] = slot_owner[g*LW +: LW];
  end

  always_comb begin
    physical  = logical & ~lane_bad;
    displaced = '0;
    for (int s = 0; s < N_SB; s++) begin
      if (slot_used[s]) begin
        displaced[s] = logical[ADDR_W + standby_pos(DATA_W, s)];
        physical[ADDR_W + standby_pos(DATA_W, s)] = logical[owner_idx[s]];
      end
    end
  end

endmodule

// File: rtl/lane_rx_merge.sv
module lane_rx_merge
  import lane_remap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int N_SB   = 4,
  localparam int LANES = ADDR_W + DATA_W,
  localparam int LW    = $clog2(LANES)
) (
  input  logic [DATA_W-1:0]    rx,
  input  logic [N_SB-1:0]      ecc_bits,
  input  logic [N_SB-1:0]      slot_used,
  input  logic [N_SB*LW-1:0]   slot_owner,
  output logic [DATA_W-1:0]    merged
);

  int owner_int [N_SB];

  for (genvar g = 0; g < N_SB; g++) begin : g_owner
    assign owner_int[g] = int'(slot_owner[g*LW +: LW]);
  end

  always_comb begin
    merged = rx;
    // standby positions are restored from ECC space
    for (int s = 0; s < N_SB; s++) begin
      if (slot_used[s]) merged[standby_pos(DATA_W, s)] = ecc_bits[s];
    end
    // broken data lanes take their bit from the standby lane
    for (int s = 0; s < N_SB; s++) begin
      if (slot_used[s] && owner_int[s] >= ADDR_W && owner_int[s] < LANES)
        merged[owner_int[s] - ADDR_W] = rx[standby_pos(DATA_W, s)];
    end
  end

endmodule

// File: rtl/tsv_lane_remap.sv
module tsv_lane_remap #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int N_SB   = 4,
  localparam int LANES = ADDR_W + DATA_W,
  localparam int LW    = $clog2(LANES),
  localparam int SW    = (N_SB > 1) ? $clog2(N_SB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [LW-1:0]     cfg_lane,
  input  logic [SW-1:0]     cfg_slot,
  output logic              cfg_err,
  input  logic              host_valid,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_rvalid,
  output logic [DATA_W-1:0] host_rdata,
  output logic              phy_valid,
  output logic              phy_we,
  output logic [LANES-1:0]  phy_tx,
  input  logic              phy_rvalid,
  input  logic [DATA_W-1:0] phy_rx,
  output logic              ecc_we,
  output logic              ecc_re,
  output logic [ADDR_W-1:0] ecc_addr,
  output logic [N_SB-1:0]   ecc_mask,
  output logic [N_SB-1:0]   ecc_wdata,
  input  logic [N_SB-1:0]   ecc_rdata
);

  logic [N_SB-1:0]    slot_used;
  logic [N_SB*LW-1:0] slot_owner;
  logic [LANES-1:0]   lane_bad;
  logic [LANES-1:0]   logical;
  logic [LANES-1:0]   physical;
  logic [N_SB-1:0]    displaced;
  logic [DATA_W-1:0]  merged;
  logic               any_used;

  lane_fault_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SB(N_SB)) u_table (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_lane   (cfg_lane),
    .cfg_slot   (cfg_slot),
    .slot_used  (slot_used),
    .slot_owner (slot_owner),
    .lane_bad   (lane_bad),
    .cfg_err    (cfg_err)
  );

  assign logical  = {(host_we ? host_wdata : {DATA_W{1'b0}}), host_addr};
  assign any_used = |slot_used;

  lane_tx_steer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SB(N_SB)) u_tx (
    .logical    (logical),
    .slot_used  (slot_used),
    .slot_owner (slot_owner),
    .lane_bad   (lane_bad),
    .physical   (physical),
    .displaced  (displaced)
  );

  lane_rx_merge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SB(N_SB)) u_rx (
    .rx         (phy_rx),
    .ecc_bits   (ecc_rdata),
    .slot_used  (slot_used),
    .slot_owner (slot_owner),
    .merged     (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phy_valid   <= 1'b0;
      phy_we      <= 1'b0;
      phy_tx      <= '0;
      ecc_we      <= 1'b0;
      ecc_re      <= 1'b0;
      ecc_addr    <= '0;
      ecc_mask    <= '0;
      ecc_wdata   <= '0;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      phy_valid   <= host_valid;
      phy_we      <= host_valid && host_we;
      phy_tx      <= host_valid ? physical : '0;
      ecc_we      <= host_valid && host_we && any_used;
      ecc_re      <= host_valid && !host_we && any_used;
      ecc_addr    <= (host_valid && any_used) ? host_addr : '0;
      ecc_mask    <= (host_valid && any_used) ? slot_used : '0;
      ecc_wdata   <= (host_valid && host_we && any_used) ? displaced : '0;
      host_rvalid <= phy_rvalid;
      host_rdata  <= phy_rvalid ? merged : '0;
    end
  end

endmodule

// File: rtl/lane_remap_checker.sv
module lane_remap_checker #(
  parameter int N_SB = 4,
  parameter int LW   = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_we,
  input logic               cfg_err,
  input logic               host_valid,
  input logic               phy_valid,
  input logic               phy_we,
  input logic               ecc_we,
  input logic               ecc_re,
  input logic               phy_rvalid,
  input logic               host_rvalid,
  input logic [N_SB-1:0]    slot_used,
  input logic [N_SB*LW-1:0] slot_owner
);

  logic dup_owner;

  always_comb begin
    dup_owner = 1'b0;
    for (int a = 0; a < N_SB; a++)
      for (int b = a + 1; b < N_SB; b++)
        if (slot_used[a] && slot_used[b] &&
            slot_owner[a*LW +: LW] == slot_owner[b*LW +: LW])
          dup_owner = 1'b1;
  end

  p_ecc_idle_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(slot_used) == '0) |-> (!ecc_we && !ecc_re));

  p_ecc_wr_r5: assert property (@(posedge clk) disable iff (rst)
    ecc_we |-> (phy_valid && phy_we));

  p_ecc_rd_r6: assert property (@(posedge clk) disable iff (rst)
    ecc_re |-> (phy_valid && !phy_we && !ecc_we));

  p_req_lat_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(host_valid)) |-> phy_valid);

  p_rsp_lat_r7: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> $past(phy_rvalid));

  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(cfg_we));

  p_unique_owner_r8: assert property (@(posedge clk) disable iff (rst)
    !dup_owner);

  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((slot_used & $past(slot_used)) == $past(slot_used)));

endmodule

bind tsv_lane_remap lane_remap_checker #(.N_SB(N_SB), .LW(LW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_we      (cfg_we),
  .cfg_err     (cfg_err),
  .host_valid  (host_valid),
  .phy_valid   (phy_valid),
  .phy_we      (phy_we),
  .ecc_we      (ecc_we),
  .ecc_re      (ecc_re),
  .phy_rvalid  (phy_rvalid),
  .host_rvalid (host_rvalid),
  .slot_used   (slot_used),
  .slot_owner  (slot_owner)
);

// File: tb/tsv_lane_remap_bench.sv
module tsv_lane_remap_bench;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int N_SB   = 4;
  localparam int LANES  = ADDR_W + DATA_W;
  localparam int LW     = $clog2(LANES);
  localparam int SW     = $clog2(N_SB);

  logic              clk = 1'b0;
  logic              rst;
  logic              cfg_we;
  logic [LW-1:0]     cfg_lane;
  logic [SW-1:0]     cfg_slot;
  logic              cfg_err;
  logic              host_valid, host_we;
  logic [ADDR_W-1:0] host_addr;
  logic [DATA_W-1:0] host_wdata;
  logic              host_rvalid;
  logic [DATA_W-1:0] host_rdata;
  logic              phy_valid, phy_we;
  logic [LANES-1:0]  phy_tx;
  logic              phy_rvalid;
  logic [DATA_W-1:0] phy_rx;
  logic              ecc_we, ecc_re;
  logic [ADDR_W-1:0] ecc_addr;
  logic [N_SB-1:0]   ecc_mask, ecc_wdata, ecc_rdata;

  always #4 clk = ~clk;

  tsv_lane_remap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SB(N_SB)) u_tsv_lane_remap (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_lane(cfg_lane), .cfg_slot(cfg_slot),
    .cfg_err(cfg_err), .host_valid(host_valid), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .phy_valid(phy_valid), .phy_we(phy_we), .phy_tx(phy_tx), .phy_rvalid(phy_rvalid),
    .phy_rx(phy_rx), .ecc_we(ecc_we), .ecc_re(ecc_re), .ecc_addr(ecc_addr),
    .ecc_mask(ecc_mask), .ecc_wdata(ecc_wdata), .ecc_rdata(ecc_rdata)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench-side repair model built from the requirements
  bit [N_SB-1:0]  m_used;
  int             m_owner [N_SB];
  bit [LANES-1:0] m_bad;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_used = '0;
    m_bad  = '0;
    for (int s = 0; s < N_SB; s++) m_owner[s] = 0;
  endtask

  // returns expected cfg_err and updates the model (R3, R8, R9, R10)
  function automatic bit model_cfg(input int lane, input int slot);
    if (lane >= LANES - N_SB) return 1'b1;
    if (m_bad[lane]) return 1'b0;
    if (m_used[slot]) return 1'b1;
    m_used[slot]   = 1'b1;
    m_owner[slot]  = lane;
    m_bad[lane]    = 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [LANES-1:0] exp_phy(input bit we, input logic [ADDR_W-1:0] a,
                                               input logic [DATA_W-1:0] d);
    logic [LANES-1:0] v, p;
    v = {(we ? d : {DATA_W{1'b0}}), a};
    p = v;
    for (int l = 0; l < LANES; l++) if (m_bad[l]) p[l] = 1'b0;
    for (int s = 0; s < N_SB; s++) if (m_used[s]) p[LANES-1-s] = v[m_owner[s]];
    return p;
  endfunction

  function automatic logic [N_SB-1:0] exp_disp(input logic [DATA_W-1:0] d);
    logic [N_SB-1:0] e;
    e = '0;
    for (int s = 0; s < N_SB; s++) if (m_used[s]) e[s] = d[DATA_W-1-s];
    return e;
  endfunction

  function automatic logic [DATA_W-1:0] exp_merge(input logic [DATA_W-1:0] rx, input logic [N_SB-1:0] e);
    logic [DATA_W-1:0] m;
    m = rx;
    for (int s = 0; s < N_SB; s++) if (m_used[s]) m[DATA_W-1-s] = e[s];
    for (int s = 0; s < N_SB; s++)
      if (m_used[s] && m_owner[s] >= ADDR_W) m[m_owner[s]-ADDR_W] = rx[DATA_W-1-s];
    return m;
  endfunction

  task automatic do_cfg(input int lane, input int slot, input string req);
    bit e;
    e = model_cfg(lane, slot);
    cfg_we   = 1'b1;
    cfg_lane = LW'(lane);
    cfg_slot = SW'(slot);
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_err == e, req, 64'(cfg_err), 64'(e));
    @(negedge clk);
    chk(cfg_err == 1'b0, "R8 cfg_err single pulse", 64'(cfg_err), 64'd0);
  endtask

  task automatic send(input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    logic [LANES-1:0] ep;
    bit any;
    ep  = exp_phy(we, a, d);
    any = |m_used;
    host_valid = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0;
    chk(phy_valid == 1'b1 && phy_we == we, "R11 phy_valid/phy_we one cycle later",
        64'({phy_valid, phy_we}), 64'({1'b1, we}));
    if (any) chk(phy_tx == ep, "R4 swapped lane image", 64'(phy_tx), 64'(ep));
    else     chk(phy_tx == ep, "R2 transparent lane image", 64'(phy_tx), 64'(ep));
    if (!any) begin
      chk({ecc_we, ecc_re, ecc_addr, ecc_mask, ecc_wdata} == '0, "R2 ecc port idle",
          64'({ecc_we, ecc_re, ecc_addr, ecc_mask, ecc_wdata}), 64'd0);
    end else if (we) begin
      chk(ecc_we && !ecc_re, "R5 ecc_we with phy write", 64'({ecc_we, ecc_re}), 64'b10);
      chk(ecc_addr == a && ecc_mask == m_used, "R5 ecc addr/mask",
          64'({ecc_addr, ecc_mask}), 64'({a, m_used}));
      chk(ecc_wdata == exp_disp(d), "R5 displaced bits", 64'(ecc_wdata), 64'(exp_disp(d)));
    end else begin
      chk(ecc_re && !ecc_we, "R6 ecc_re with phy read", 64'({ecc_we, ecc_re}), 64'b01);
      chk(ecc_addr == a && ecc_mask == m_used, "R6 ecc addr/mask",
          64'({ecc_addr, ecc_mask}), 64'({a, m_used}));
    end
  endtask

  task automatic ret(input logic [DATA_W-1:0] rx, input logic [N_SB-1:0] e, input logic [DATA_W-1:0] expd,
                     input string req);
    phy_rvalid = 1'b1; phy_rx = rx; ecc_rdata = e;
    @(negedge clk);
    phy_rvalid = 1'b0;
    chk(host_rvalid == 1'b1, "R11 host_rvalid one cycle later", 64'(host_rvalid), 64'd1);
    chk(host_rdata == expd, req, 64'(host_rdata), 64'(expd));
  endtask

  task automatic round_trip(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] stored;
    logic [N_SB-1:0]   estore;
    send(1'b1, a, d);
    stored = phy_tx[LANES-1:ADDR_W];
    estore = ecc_wdata;
    for (int l = ADDR_W; l < LANES; l++)
      if (m_bad[l]) stored[l-ADDR_W] = ~stored[l-ADDR_W];
    send(1'b0, a, '0);
    ret(stored, estore, d, "R12 round trip restores write data");
  endtask

  task automatic random_traffic(input int n);
    for (int i = 0; i < n; i++) begin
      send(1'($urandom), ADDR_W'($urandom), DATA_W'($urandom));
    end
  endtask

  task automatic random_returns(input int n);
    for (int i = 0; i < n; i++) begin
      logic [DATA_W-1:0] rx;
      logic [N_SB-1:0]   e;
      rx = DATA_W'($urandom);
      e  = N_SB'($urandom);
      ret(rx, e, exp_merge(rx, e), "R7 read merge");
    end
  endtask

  initial begin
    void'($urandom(32'd20140614));
    rst = 1'b1; cfg_we = 0; cfg_lane = '0; cfg_slot = '0;
    host_valid = 0; host_we = 0; host_addr = '0; host_wdata = '0;
    phy_rvalid = 0; phy_rx = '0; ecc_rdata = '0;
    model_clear();
    repeat (3) @(negedge clk);
    chk({cfg_err, host_rvalid, host_rdata, phy_valid, phy_we, phy_tx} == '0,
        "R1 outputs zero in reset", 64'(phy_tx), 64'd0);
    chk({ecc_we, ecc_re, ecc_addr, ecc_mask, ecc_wdata} == '0, "R1 ecc zero in reset",
        64'({ecc_addr, ecc_mask, ecc_wdata}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(phy_valid == 1'b0 && host_rvalid == 1'b0, "R1 idle after reset",
        64'({phy_valid, host_rvalid}), 64'd0);

    // no repairs: transparent
    send(1'b1, 16'hFFFF, 32'hFFFF_FFFF);
    send(1'b0, 16'hA5A5, 32'h1234_5678);
    random_traffic(16);
    random_returns(6);

    // accepted repairs: an address lane and a data lane
    do_cfg(3, 0, "R3 accept address lane 3 on slot 0");
    do_cfg(ADDR_W + 5, 2, "R3 accept data lane 5 on slot 2");
    send(1'b1, 16'h0008, 32'h0000_0020);
    send(1'b0, 16'hFFF7, 32'h0);

    // conflicts and invalid targets
    do_cfg(7, 0, "R8 slot 0 already owned");
    send(1'b1, 16'h0080, 32'h8000_0000);
    do_cfg(LANES - 1, 1, "R9 standby lane rejected");
    do_cfg(LANES - N_SB, 1, "R9 lowest standby lane rejected");
    do_cfg(60, 1, "R9 out of range lane rejected");
    do_cfg(3, 1, "R10 re-mark of repaired lane ignored");
    send(1'b1, 16'h0008, 32'h4000_0000);

    random_traffic(30);
    random_returns(20);
    for (int i = 0; i < 10; i++) round_trip(ADDR_W'($urandom), DATA_W'($urandom));

    // fill the remaining slots
    do_cfg(ADDR_W + 4, 1, "R3 accept data lane 4 on slot 1");
    do_cfg(10, 3, "R3 accept address lane 10 on slot 3");
    do_cfg(ADDR_W + 6, 3, "R8 all slots owned");
    random_traffic(30);
    random_returns(20);
    for (int i = 0; i < 10; i++) round_trip(ADDR_W'($urandom), DATA_W'($urandom));
    round_trip(16'hFFFF, 32'hFFFF_FFFF);
    round_trip(16'h0000, 32'h0000_0000);

    // reset clears repairs
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    @(negedge clk);
    send(1'b1, 16'h0408, 32'h8000_0030);
    chk(phy_tx[3] == 1'b1 && ecc_we == 1'b0, "R10 reset clears repairs",
        64'({phy_tx[3], ecc_we}), 64'b10);
    random_traffic(8);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R11 act=hung exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule